// File: doc/BRIEF.md
# Strap-or-Serial Configuration Controller

This block holds the configuration of a receiver and gives it two ways in. When the strap-enable pin is high, the three pins of the serial port are read as steady logic levels. Together they form a 3-bit index that picks one of eight built-in configurations. When the strap-enable pin is low, the same three pins act as a 3-wire write-only serial port with a clock, an active-low select and a data line. The port carries 32-bit words, and each word updates one register of a small configuration bank.

The decoded fields leave the block as plain outputs: the reference divider, the main divider, the number of output bits and the filter-order select. All pins are brought into the system clock domain through synchronisers before the block reacts to them. At reset the bank takes the values of configuration 0. A word counts only if it was framed by exactly 32 serial clock edges. When the strap-enable pin falls, the bank keeps the last configuration it was given, and serial writes then replace it field by field.

Top module: `strap_serial_cfg`

## Requirements
- R1: After reset, with strap-enable low, the outputs are ref_div=16, main_div=1536, out_bits=1 and filt_hi=1.
- R2: With strap-enable high, the preset index is {ser_clk, ser_dat, ser_sel_n}: ser_clk is bit 2 and ser_sel_n is bit 0.
- R3: Presets 0, 1, 2 and 6 give dividers 16/1536. Preset 3 gives 32/1536, preset 4 gives 96/7857, preset 5 gives 26/1488 and preset 7 gives 26/1508 (reference/main).
- R4: out_bits is 1 for presets 0 and 1, 2 for presets 2 to 4, and 3 for presets 5 to 7. filt_hi is 0 only for preset 1.
- R5: In serial mode a word enters MSB first, one bit per rising edge of ser_clk, and only while ser_sel_n is low. Bits 31..4 are the data field and bits 3..0 the address. Address 0 sets ref_div=data[9:0] and main_div=data[24:10]. Address 1 sets out_bits=data[1:0] and filt_hi=data[2].
- R6: A word is written on the rising edge of ser_sel_n only when exactly 32 rising edges of ser_clk were counted during the select. A word framed by 31 or by 33 edges changes no output.
- R7: A complete word sent to any address from 2 to 15 changes no output.
- R8: With strap-enable high, serial traffic writes nothing. Afterwards the outputs equal the preset chosen by the final pin levels.
- R9: When strap-enable falls, the outputs keep the last preset until a serial write replaces them.
- R10: The outputs change on the third system clock edge after ser_sel_n rises, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_en | input | 1 | High: pins select a preset; low: serial programming |
| ser_clk | input | 1 | Serial clock, or preset index bit 2 |
| ser_sel_n | input | 1 | Active-low serial select, or preset index bit 0 |
| ser_dat | input | 1 | Serial data, or preset index bit 1 |
| ref_div | output | 10 | Reference divider value |
| main_div | output | 15 | Main divider value |
| out_bits | output | 2 | Number of output bits |
| filt_hi | output | 1 | 1 selects the higher filter order |

## Verification
Every pin goes through a two-stage synchroniser, and the bank is one register further on. A change on a pin therefore shows at the outputs three system clock edges later. This applies both to a preset selected by strap levels and to a committed serial word. The bench checks this timing directly on one write: two falling clock edges after the select rises, the old value must still be present, and one falling edge later, the new value. For every other case the driver waits at least six cycles after its last pin change before it queues the expected fields. The monitor then compares them on a falling edge, well clear of the update. Serial bits are held for four system cycles on each side of a serial clock edge, so the data is settled before its synchronised clock rises.

// File: rtl/cfgc_pkg.sv
package cfgc_pkg;
  localparam int REF_W   = 10;
  localparam int MAIN_W  = 15;
  localparam int BITS_W  = 2;
  localparam int WORD_W  = 32;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = WORD_W - ADDR_W;
  localparam int IDX_W   = 3;

  typedef struct packed {
    logic [REF_W-1:0]  ref_div;
    logic [MAIN_W-1:0] main_div;
    logic [BITS_W-1:0] out_bits;
    logic              filt_hi;
  } cfg_t;

  // Built-in configuration table, indexed by strap level code.
  function automatic cfg_t preset_cfg(input logic [IDX_W-1:0] idx);
    cfg_t c;
    c.filt_hi  = (idx != 3'd1);
    c.out_bits = (idx <= 3'd1) ? BITS_W'(1) :
                 (idx <= 3'd4) ? BITS_W'(2) : BITS_W'(3);
    case (idx)
      3'd3:    begin c.ref_div = REF_W'(32); c.main_div = MAIN_W'(1536); end
      3'd4:    begin c.ref_div = REF_W'(96); c.main_div = MAIN_W'(7857); end
      3'd5:    begin c.ref_div = REF_W'(26); c.main_div = MAIN_W'(1488); end
      3'd7:    begin c.ref_div = REF_W'(26); c.main_div = MAIN_W'(1508); end
      default: begin c.ref_div = REF_W'(16); c.main_div = MAIN_W'(1536); end
    endcase
    return c;
  endfunction

  // Merge one serial word into the current configuration.
  function automatic cfg_t apply_write(input cfg_t cur,
                                       input logic [ADDR_W-1:0] addr,
                                       input logic [DATA_W-1:0] data);
    cfg_t c;
    c = cur;
    if (addr == ADDR_W'(0)) begin
      c.ref_div  = data[REF_W-1:0];
      c.main_div = data[REF_W+MAIN_W-1:REF_W];
    end else if (addr == ADDR_W'(1)) begin
      c.out_bits = data[BITS_W-1:0];
      c.filt_hi  = data[BITS_W];
    end
    return c;
  endfunction
endpackage

// File: rtl/cfgc_sync.sv
module cfgc_sync #(
  parameter int W        = 4,
  parameter int STAGES   = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/cfgc_shifter.sv
module cfgc_shifter #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sclk_s,
  input  logic              sel_n_s,
  input  logic              dat_s,
  output logic              sclk_rise,
  output logic              sel_rise,
  output logic              commit,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_MAX = WORD_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             sclk_q, sel_q;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sel_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      sel_q  <= sel_n_s;
    end
  end

  assign sclk_rise = en && !sel_n_s && sclk_s && !sclk_q;
  assign sel_rise  = en && sel_n_s && !sel_q;
  assign commit    = sel_rise && (cnt == CNT_W'(WORD_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else if (sclk_rise) begin
      word <= {word[WORD_W-2:0], dat_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en || sel_n_s) begin
      cnt <= '0;
    end else if (sclk_rise && cnt != CNT_W'(CNT_MAX)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_cnt_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(CNT_MAX));
  assert_commit_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (cnt == '0));
  assert_shift_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(word));
endmodule

// File: rtl/cfgc_bank.sv
module cfgc_bank
  import cfgc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  output cfg_t              cfg
);
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  assign wr_addr = wr_word[ADDR_W-1:0];
  assign wr_data = wr_word[WORD_W-1:ADDR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg <= preset_cfg('0);
    else if (strap)  cfg <= preset_cfg(idx);
    else if (wr_en)  cfg <= apply_write(cfg, wr_addr, wr_data);
  end

  assert_unused_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !strap && wr_addr > ADDR_W'(1)) |=> $stable(cfg));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!strap && !wr_en) |=> $stable(cfg));
endmodule

// File: rtl/strap_serial_cfg.sv
module strap_serial_cfg
  import cfgc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_en,
  input  logic              ser_clk,
  input  logic              ser_sel_n,
  input  logic              ser_dat,
  output logic [REF_W-1:0]  ref_div,
  output logic [MAIN_W-1:0] main_div,
  output logic [BITS_W-1:0] out_bits,
  output logic              filt_hi
);
  logic [3:0]        pins_s;
  logic              strap_s, sclk_s, sel_n_s, dat_s;
  logic              sclk_rise, sel_rise, commit;
  logic [WORD_W-1:0] word;
  cfg_t              cfg;

  cfgc_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0010)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({strap_en, ser_clk, ser_sel_n, ser_dat}),
    .dout (pins_s)
  );

  assign {strap_s, sclk_s, sel_n_s, dat_s} = pins_s;

  cfgc_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (!strap_s),
    .sclk_s   (sclk_s),
    .sel_n_s  (sel_n_s),
    .dat_s    (dat_s),
    .sclk_rise(sclk_rise),
    .sel_rise (sel_rise),
    .commit   (commit),
    .word     (word)
  );

  cfgc_bank u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .strap  (strap_s),
    .idx    ({sclk_s, dat_s, sel_n_s}),
    .wr_en  (commit),
    .wr_word(word),
    .cfg    (cfg)
  );

  assign ref_div  = cfg.ref_div;
  assign main_div = cfg.main_div;
  assign out_bits = cfg.out_bits;
  assign filt_hi  = cfg.filt_hi;

  assert_quiet_in_strap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strap_s |-> (!commit && !sclk_rise && !sel_rise));
endmodule

// File: tb/strap_serial_cfg_tb.sv
module strap_serial_cfg_tb;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic strap_en = 1'b0, ser_clk = 1'b0, ser_sel_n = 1'b1, ser_dat = 1'b0;
  logic [9:0]  ref_div;
  logic [14:0] main_div;
  logic [1:0]  out_bits;
  logic        filt_hi;

  int n_checks = 0, n_errors = 0;
  int q_ref[$], q_main[$], q_bits[$], q_filt[$];
  string q_tag[$];
  int m_ref, m_main, m_bits, m_filt;

  localparam int TAB_REF  [8] = '{16, 16, 16, 32, 96, 26, 16, 26};
  localparam int TAB_MAIN [8] = '{1536, 1536, 1536, 1536, 7857, 1488, 1536, 1508};

  always #(CLK_NS/2) clk = ~clk;

  strap_serial_cfg u_dut (
    .clk(clk), .rst_n(rst_n), .strap_en(strap_en), .ser_clk(ser_clk),
    .ser_sel_n(ser_sel_n), .ser_dat(ser_dat), .ref_div(ref_div),
    .main_div(main_div), .out_bits(out_bits), .filt_hi(filt_hi)
  );

  task automatic check(input string tag, input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic expect_model(input string tag);
    q_tag.push_back(tag);
    q_ref.push_back(m_ref);
    q_main.push_back(m_main);
    q_bits.push_back(m_bits);
    q_filt.push_back(m_filt);
  endtask

  task automatic load_preset_model(input int k);
    m_ref  = TAB_REF[k];
    m_main = TAB_MAIN[k];
    m_bits = (k < 2) ? 1 : ((k < 5) ? 2 : 3);
    m_filt = (k == 1) ? 0 : 1;
  endtask

  // monitor: compare queued expectations on falling edges
  initial begin
    forever begin
      @(negedge clk);
      while (q_tag.size() > 0) begin
        string t;
        t = q_tag.pop_front();
        check(t, "ref_div",  int'(ref_div),  q_ref.pop_front());
        check(t, "main_div", int'(main_div), q_main.pop_front());
        check(t, "out_bits", int'(out_bits), q_bits.pop_front());
        check(t, "filt_hi",  int'(filt_hi),  q_filt.pop_front());
      end
    end
  end

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  // Frame a word with the given number of serial clock edges; returns
  // at the falling system edge on which the select is raised.
  task automatic send_word(input logic [31:0] w, input int edges);
    @(negedge clk); ser_sel_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < edges; k++) begin
      ser_dat = (k < 32) ? w[31-k] : 1'b0;
      repeat (4) @(negedge clk); ser_clk = 1'b1;
      repeat (4) @(negedge clk); ser_clk = 1'b0;
    end
    ser_dat = 1'b0;
    repeat (4) @(negedge clk); ser_sel_n = 1'b1;
  endtask

  function automatic logic [31:0] mk(input int data, input int addr);
    return {data[27:0], addr[3:0]};
  endfunction

  initial begin
    #(CLK_NS * 200000);
    n_checks++; n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1: reset values
    load_preset_model(0);
    expect_model("R1 reset");
    settle();

    // R2 R3 R4: every preset through the strap pins
    strap_en = 1'b1;
    for (int k = 0; k < 8; k++) begin
      ser_clk = k[2]; ser_dat = k[1]; ser_sel_n = k[0];
      settle();
      load_preset_model(k);
      expect_model($sformatf("R2/R3/R4 preset %0d", k));
      settle();
    end

    // R9: strap released, preset 7 kept
    strap_en = 1'b0;
    settle();
    ser_clk = 1'b0; ser_dat = 1'b0;
    settle();
    expect_model("R9 hold after strap low");
    settle();

    // R5 R10: write address 0, watch the timing
    send_word(mk((12345 << 10) | 200, 0), 32);
    @(negedge clk); @(negedge clk);
    check("R10", "ref_div before", int'(ref_div), m_ref);
    @(negedge clk);
    check("R10", "ref_div after", int'(ref_div), 200);
    m_ref = 200; m_main = 12345;
    settle();
    expect_model("R5 addr0 write");
    settle();

    // R5: address 1 write
    send_word(mk(1, 1), 32);
    settle();
    m_bits = 1; m_filt = 0;
    expect_model("R5 addr1 write");
    settle();

    // R6: short and long frames discarded
    send_word(mk(5, 0), 31);
    settle();
    expect_model("R6 31 edges");
    settle();
    send_word(mk(7, 0), 33);
    settle();
    expect_model("R6 33 edges");
    settle();

    // R7: unused address
    send_word(mk(28'hFFF_FFFF, 9), 32);
    settle();
    expect_model("R7 unused addr");
    settle();
    send_word(mk(6, 2), 32);
    settle();
    expect_model("R7 addr2");
    settle();

    // R8: traffic while strapped; pins end as index 1
    strap_en = 1'b1;
    settle();
    send_word(mk(99, 0), 32);
    settle();
    load_preset_model(1);
    expect_model("R8 strap traffic");
    settle();

    while (q_tag.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule